// File: doc/BRIEF.md
# Host Frame Mailbox

This block is the peripheral end of a 16-bit memory-mapped mailbox that carries whole frames between a host processor and a byte-wide frame link. The host sees two word locations: a shared data port at byte offset 0 and a command register at byte offset 4. Commands written to the command register choose what a data-port read returns: the byte count of the held receive frame, its payload, a status word or a checksum. Other commands end a transmit frame or select the operating mode.

Received link frames are checked and held in a one-frame buffer. A valid frame raises a single-cycle receive interrupt. The host then asks for the length, starts a read burst and reads the payload two bytes per word. Reading the final word frees the buffer. To transmit, the host writes payload words to the data port, using byte lanes to mark an odd trailing byte, and then issues end-of-frame. The block plays the frame out on the link stream and raises a single-cycle transmit interrupt once the last byte has been taken. At start-up the host writes the standalone mode code.

Top module: `hfm_mailbox`

## Requirements
- R1: After reset, rx_irq, tx_irq and tx_valid are low, op_mode is 0 (unset), and a data-port read returns 0 until a read-select command is written.
- R2: When a link frame is accepted, rx_irq is high for exactly one cycle, in the cycle after the edge that takes the frame's last byte. After command 0x0002, a data-port read returns the held frame's byte count.
- R3: After command 0x0008, successive data-port reads return the frame two bytes per word, with byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. For an odd count, the final word has its last byte in bits 7:0 and zero in bits 15:8. The read of the final word frees the buffer, and the length then reads 0.
- R4: A link frame is discarded, with no rx_irq and the drop counter increased by one, if it is shorter than 3 bytes, longer than DEPTH bytes, or if its inner length {byte1[1:0], byte0} exceeds its byte count. The upper six bits of byte 1 are not part of the inner length.
- R5: A link frame that starts while a frame is held is discarded as a whole and counted as a drop. The held frame's length and payload are unchanged.
- R6: Data-port writes store transmit bytes. Lane bits 7:0 (be[0]) come before lane bits 15:8 (be[1]), and a lane whose enable is low is not stored. Nothing is sent before command 0x0001. After it, tx_valid rises and the bytes leave in written order, with tx_last on the final byte only. While tx_ready is low, tx_valid, tx_data and tx_last hold.
- R7: tx_irq is high for exactly one cycle, in the cycle after the edge that takes the final transmit byte. Data-port writes made while a frame is draining are ignored. End-of-frame with no bytes stored starts nothing and raises no interrupt.
- R8: Mode command 0x0010 sets op_mode to 1, 0x0020 sets it to 2 and 0x0040 sets it to 3. Command 0x0080 and codes the block does not know leave op_mode and the read selection unchanged.
- R9: After command 0x0100, a data-port read returns the drop count in bits 15:8, the transmit-busy flag in bit 1 and the frame-held flag in bit 0. All other bits are zero.
- R10: After command 0x0200, a data-port read returns the sum modulo 256 of the held frame's bytes in bits 7:0, with zero above.
- R11: Accesses to byte offsets other than 0 and 4 have no effect and read 0. A read of offset 4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Host access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset: 0 data port, 4 command register |
| bus_be | input | 2 | Byte-lane enables for data-port writes |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, valid during a read access |
| rx_valid | input | 1 | Link receive byte valid |
| rx_data | input | 8 | Link receive byte |
| rx_last | input | 1 | Final byte of the receive frame |
| tx_valid | output | 1 | Link transmit byte valid |
| tx_data | output | 8 | Link transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| tx_ready | input | 1 | Link accepts the transmit byte |
| rx_irq | output | 1 | One-cycle pulse: a frame is held |
| tx_irq | output | 1 | One-cycle pulse: transmit frame drained |
| op_mode | output | 2 | Selected operating mode (0 unset) |

## Verification
Read data comes straight from state through logic, so the bench samples bus_rdata 1 time unit into a read access, before the clock edge that advances the burst pointer. Command and mode effects are due on that edge, so they are checked 1 unit after it. rx_irq is due in the cycle after the edge that takes a frame's last byte. tx_irq is due in the cycle after the edge that takes the final transmit byte. Both pulses are sampled at the next falling edge and again one cycle later, to confirm they last a single cycle. Transmit bytes are collected at the falling edge only when tx_valid and tx_ready are both high, which makes a handshake due on the following rising edge.

// File: rtl/hfm_pkg.sv
package hfm_pkg;

    // command codes written to the command register
    localparam logic [15:0] CMD_EOF        = 16'h0001;
    localparam logic [15:0] CMD_LEN        = 16'h0002;
    localparam logic [15:0] CMD_BURST      = 16'h0008;
    localparam logic [15:0] CMD_MODE_SA    = 16'h0010;
    localparam logic [15:0] CMD_MODE_RELAY = 16'h0020;
    localparam logic [15:0] CMD_MODE_PASS  = 16'h0040;
    localparam logic [15:0] CMD_DIR        = 16'h0080;
    localparam logic [15:0] CMD_STATUS     = 16'h0100;
    localparam logic [15:0] CMD_SUM        = 16'h0200;

    localparam logic [2:0] ADDR_DATA = 3'd0;
    localparam logic [2:0] ADDR_CMD  = 3'd4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEN,
        SEL_BURST,
        SEL_STATUS,
        SEL_SUM
    } rsel_e;

    typedef enum logic [1:0] {
        MODE_UNSET,
        MODE_STANDALONE,
        MODE_RELAY,
        MODE_PASS
    } op_mode_e;

    typedef struct packed {
        logic     eof;
        logic     set_sel;
        rsel_e    sel;
        logic     set_mode;
        op_mode_e mode;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [15:0] code);
        cmd_t c;
        c.eof      = 1'b0;
        c.set_sel  = 1'b0;
        c.sel      = SEL_NONE;
        c.set_mode = 1'b0;
        c.mode     = MODE_UNSET;
        case (code)
            CMD_EOF:        c.eof = 1'b1;
            CMD_LEN:        begin c.set_sel = 1'b1; c.sel = SEL_LEN;    end
            CMD_BURST:      begin c.set_sel = 1'b1; c.sel = SEL_BURST;  end
            CMD_STATUS:     begin c.set_sel = 1'b1; c.sel = SEL_STATUS; end
            CMD_SUM:        begin c.set_sel = 1'b1; c.sel = SEL_SUM;    end
            CMD_MODE_SA:    begin c.set_mode = 1'b1; c.mode = MODE_STANDALONE; end
            CMD_MODE_RELAY: begin c.set_mode = 1'b1; c.mode = MODE_RELAY;      end
            CMD_MODE_PASS:  begin c.set_mode = 1'b1; c.mode = MODE_PASS;       end
            CMD_DIR:        c.eof = 1'b0; // accepted, no effect
            default:        c.eof = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic [15:0] status_word(input logic [7:0] drops,
                                                input logic       tx_busy,
                                                input logic       rx_held);
        return {drops, 6'b000000, tx_busy, rx_held};
    endfunction

endpackage

// File: rtl/hfm_host_port.sv
module hfm_host_port
    import hfm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cs,
    input  logic        we,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic        data_rd,
    output logic        data_wr,
    output logic        eof,
    output logic        burst_start,
    output rsel_e       rsel,
    output op_mode_e    mode
);
    logic cmd_wr;
    cmd_t dec;

    assign cmd_wr  = cs && we && (addr == ADDR_CMD);
    assign data_rd = cs && !we && (addr == ADDR_DATA);
    assign data_wr = cs && we && (addr == ADDR_DATA);
    assign dec     = decode_cmd(wdata);

    assign eof         = cmd_wr && dec.eof;
    assign burst_start = cmd_wr && dec.set_sel && (dec.sel == SEL_BURST);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsel <= SEL_NONE;
            mode <= MODE_UNSET;
        end else if (cmd_wr) begin
            if (dec.set_sel)  rsel <= dec.sel;
            if (dec.set_mode) mode <= dec.mode;
        end
    end
endmodule

// File: rtl/hfm_rx_frame.sv
module hfm_rx_frame #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lk_valid,
    input  logic [7:0]                   lk_data,
    input  logic                         lk_last,
    input  logic                         burst_start,
    input  logic                         burst_rd,
    output logic                         held,
    output logic [$clog2(DEPTH+1)-1:0]   len,
    output logic [7:0]                   sum,
    output logic [15:0]                  word,
    output logic [7:0]                   drop_cnt,
    output logic                         irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] wcnt, byte_idx, len_q, rd_ptr;
    logic [CNT_W:0]   total, lo_idx, hi_idx, len_x;
    logic [9:0]       inner;
    logic [7:0]       sum_q, lo_b, hi_b;
    logic             in_frame, skip_q, ovf_q, held_q;
    logic             cur_skip, ovf_now, frame_ok, last_word;

    // frame-in-progress bookkeeping
    assign byte_idx = in_frame ? wcnt : '0;
    assign cur_skip = in_frame ? skip_q : held_q;
    assign ovf_now  = (in_frame && ovf_q) || (byte_idx >= CNT_W'(DEPTH));
    assign total    = {1'b0, byte_idx} + (CNT_W+1)'(1);
    assign inner    = {mem[1][1:0], mem[0]};
    assign frame_ok = !ovf_now && (total >= (CNT_W+1)'(3))
                      && (32'(inner) <= 32'(total));

    // host-side word view of the held frame
    assign len_x     = {1'b0, len_q};
    assign lo_idx    = {rd_ptr, 1'b0};
    assign hi_idx    = lo_idx + (CNT_W+1)'(1);
    assign lo_b      = (held_q && lo_idx < len_x) ? mem[lo_idx[PTR_W-1:0]] : 8'h00;
    assign hi_b      = (held_q && hi_idx < len_x) ? mem[hi_idx[PTR_W-1:0]] : 8'h00;
    assign last_word = (lo_idx + (CNT_W+1)'(2)) >= len_x;

    assign word = {hi_b, lo_b};
    assign held = held_q;
    assign len  = held_q ? len_q : '0;
    assign sum  = held_q ? sum_q : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            len_q    <= '0;
            rd_ptr   <= '0;
            sum_q    <= 8'h00;
            in_frame <= 1'b0;
            skip_q   <= 1'b0;
            ovf_q    <= 1'b0;
            held_q   <= 1'b0;
            drop_cnt <= 8'h00;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (lk_valid) begin
                if (!cur_skip && !ovf_now)
                    mem[byte_idx[PTR_W-1:0]] <= lk_data;
                if (!cur_skip)
                    sum_q <= (in_frame ? sum_q : 8'h00) + lk_data;
                in_frame <= !lk_last;
                skip_q   <= cur_skip;
                ovf_q    <= ovf_now;
                wcnt     <= ovf_now ? byte_idx : byte_idx + CNT_W'(1);
                if (lk_last) begin
                    if (!cur_skip && frame_ok) begin
                        held_q <= 1'b1;
                        len_q  <= total[CNT_W-1:0];
                        irq    <= 1'b1;
                    end else begin
                        drop_cnt <= drop_cnt + 8'h01;
                    end
                end
            end
            if (burst_start) begin
                rd_ptr <= '0;
            end else if (burst_rd && held_q) begin
                rd_ptr <= rd_ptr + CNT_W'(1);
                if (last_word) held_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hfm_tx_frame.sv
module hfm_tx_frame #(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    input  logic        eof,
    output logic        lk_valid,
    output logic [7:0]  lk_data,
    output logic        lk_last,
    input  logic        lk_ready,
    output logic        busy,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] wp, rp, idx1;
    logic             add0, add1, fire;

    assign add0 = wr && !busy && be[0] && (wp < CNT_W'(DEPTH));
    assign idx1 = wp + CNT_W'(add0);
    assign add1 = wr && !busy && be[1] && (idx1 < CNT_W'(DEPTH));

    assign lk_valid = busy;
    assign lk_data  = mem[rp[PTR_W-1:0]];
    assign lk_last  = busy && (rp == wp - CNT_W'(1));
    assign fire     = busy && lk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            busy <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (add0) mem[wp[PTR_W-1:0]]   <= wdata[7:0];
            if (add1) mem[idx1[PTR_W-1:0]] <= wdata[15:8];
            if (!busy) begin
                wp <= idx1 + CNT_W'(add1);
                if (eof && wp != '0) begin
                    busy <= 1'b1;
                    rp   <= '0;
                end
            end else if (fire) begin
                if (lk_last) begin
                    busy <= 1'b0;
                    wp   <= '0;
                    irq  <= 1'b1;
                end else begin
                    rp <= rp + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/hfm_mailbox.sv
module hfm_mailbox
    import hfm_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_cs,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        rx_irq,
    output logic        tx_irq,
    output logic [1:0]  op_mode
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             data_rd, data_wr, eof, burst_start, burst_rd;
    rsel_e            rsel;
    op_mode_e         mode;
    logic             rx_held, tx_busy;
    logic [CNT_W-1:0] rx_len;
    logic [7:0]       rx_sum, drop_cnt;
    logic [15:0]      rx_word;

    hfm_host_port u_host (
        .clk(clk), .rst(rst), .cs(bus_cs), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .data_rd(data_rd), .data_wr(data_wr), .eof(eof),
        .burst_start(burst_start), .rsel(rsel), .mode(mode)
    );

    assign burst_rd = data_rd && (rsel == SEL_BURST);

    hfm_rx_frame #(.DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst(rst), .lk_valid(rx_valid), .lk_data(rx_data),
        .lk_last(rx_last), .burst_start(burst_start), .burst_rd(burst_rd),
        .held(rx_held), .len(rx_len), .sum(rx_sum), .word(rx_word),
        .drop_cnt(drop_cnt), .irq(rx_irq)
    );

    hfm_tx_frame #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .wr(data_wr), .be(bus_be), .wdata(bus_wdata),
        .eof(eof), .lk_valid(tx_valid), .lk_data(tx_data), .lk_last(tx_last),
        .lk_ready(tx_ready), .busy(tx_busy), .irq(tx_irq)
    );

    assign op_mode = mode;

    always_comb begin
        bus_rdata = 16'h0000;
        if (data_rd) begin
            case (rsel)
                SEL_LEN:    bus_rdata = 16'(rx_len);
                SEL_BURST:  bus_rdata = rx_word;
                SEL_STATUS: bus_rdata = status_word(drop_cnt, tx_busy, rx_held);
                SEL_SUM:    bus_rdata = {8'h00, rx_sum};
                default:    bus_rdata = 16'h0000;
            endcase
        end
    end
endmodule

// File: rtl/hfm_mailbox_checker.sv
module hfm_mailbox_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       rx_last,
    input logic       rx_irq,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_last,
    input logic [7:0] tx_data,
    input logic       tx_irq
);
    AST_RX_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq); // R2
    AST_RX_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> $past(rx_valid && rx_last)); // R2
    AST_TX_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid); // R6
    AST_TX_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6
    AST_TX_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> $past(tx_valid && tx_ready && tx_last)); // R7
    AST_TX_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq); // R7
endmodule

bind hfm_mailbox hfm_mailbox_checker u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_irq(rx_irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .tx_data(tx_data), .tx_irq(tx_irq)
);

// File: tb/hfm_mailbox_test.sv
module hfm_mailbox_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    typedef struct packed {
        logic [7:0] len;
        logic [9:0] inner;
        logic       ok;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd3,  10'd3,    1'b1},
        '{8'd4,  10'd2,    1'b1},
        '{8'd5,  10'd5,    1'b1},
        '{8'd2,  10'd0,    1'b0},
        '{8'd1,  10'd0,    1'b0},
        '{8'd10, 10'd11,   1'b0},
        '{8'd64, 10'd64,   1'b1},
        '{8'd65, 10'd0,    1'b0},
        '{8'd9,  10'd4,    1'b1},
        '{8'd7,  10'd1023, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_cs, bus_we;
    logic [2:0]  bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata, bus_rdata;
    logic        rx_valid, rx_last;
    logic [7:0]  rx_data;
    logic        tx_valid, tx_last, tx_ready;
    logic [7:0]  tx_data;
    logic        rx_irq, tx_irq;
    logic [1:0]  op_mode;

    int checks = 0;
    int fails  = 0;
    int drops  = 0;
    logic [15:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    hfm_mailbox #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_ready(tx_ready), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .op_mode(op_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rxb(input int len, input logic [9:0] inner, input int i);
        if (i == 0) return inner[7:0];
        if (i == 1) return {6'h2A, inner[9:8]};
        return 8'(i * 13 + len);
    endfunction

    function automatic logic [7:0] txb(input int n, input int i);
        return 8'(i * 29 + 5 + n);
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk);
        #1 bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_cs = 1'b0;
    endtask

    task automatic send_frame(input int len, input logic [9:0] inner, input logic exp_irq);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = rxb(len, inner, i);
            rx_last  = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        check("R2/R4 rx_irq after last byte", 32'(rx_irq), 32'(exp_irq));
        @(negedge clk);
        check("R2 rx_irq single cycle", 32'(rx_irq), 32'd0);
    endtask

    task automatic read_status(input string req, input logic [15:0] exp);
        logic [15:0] d;
        bus_write(3'd4, 16'h0100, 2'b11);
        bus_read(3'd0, d);
        check(req, 32'(d), 32'(exp));
    endtask

    task automatic check_held(input int len, input logic [9:0] inner);
        logic [15:0] d;
        logic [7:0]  s;
        s = 8'h00;
        for (int i = 0; i < len; i++) s = s + rxb(len, inner, i);
        bus_write(3'd4, 16'h0002, 2'b11);
        bus_read(3'd0, d);
        check("R2 length read", 32'(d), 32'(len));
        bus_write(3'd4, 16'h0200, 2'b11);
        bus_read(3'd0, d);
        check("R10 checksum", 32'(d), {24'h0, s});
        bus_write(3'd4, 16'h0008, 2'b11);
        for (int w = 0; w < (len + 1) / 2; w++) begin
            logic [7:0] hi;
            hi = (2 * w + 1 < len) ? rxb(len, inner, 2 * w + 1) : 8'h00;
            bus_read(3'd0, d);
            check("R3 burst word", 32'(d), {16'h0, hi, rxb(len, inner, 2 * w)});
        end
        bus_write(3'd4, 16'h0002, 2'b11);
        bus_read(3'd0, d);
        check("R3 length after release", 32'(d), 32'd0);
    endtask

    task automatic tx_frame(input int n, input logic stall, input logic poke);
        int k;
        int cyc;
        logic done;
        for (int w = 0; w < n; w += 2) begin
            if (w + 1 < n) bus_write(3'd0, {txb(n, w + 1), txb(n, w)}, 2'b11);
            else           bus_write(3'd0, {8'hEE, txb(n, w)}, 2'b01);
        end
        check("R6 nothing sent before end-of-frame", 32'(tx_valid), 32'd0);
        bus_write(3'd4, 16'h0001, 2'b11);
        check("R6 tx_valid after end-of-frame", 32'(tx_valid), 32'd1);
        if (poke) bus_write(3'd0, 16'hBEEF, 2'b11);
        k = 0; cyc = 0; done = 1'b0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
            cyc++;
            #1;
            if (tx_valid && tx_ready) begin
                check("R6 tx byte order", 32'(tx_data), 32'(txb(n, k)));
                check("R6 tx_last position", 32'(tx_last), 32'(k == n - 1));
                k++;
                if (k == n) begin
                    @(negedge clk);
                    tx_ready = 1'b0;
                    check("R7 tx_irq after final byte", 32'(tx_irq), 32'd1);
                    @(negedge clk);
                    check("R7 tx_irq single cycle", 32'(tx_irq), 32'd0);
                    check("R7 idle after drain", 32'(tx_valid), 32'd0);
                    done = 1'b1;
                end
            end
        end
        check("R7 byte count, late writes ignored", 32'(k), 32'(n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_cs = 1'b0; bus_we = 1'b0; bus_addr = 3'd0; bus_be = 2'b00;
        bus_wdata = 16'h0000; rx_valid = 1'b0; rx_data = 8'h00; rx_last = 1'b0;
        tx_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 tx_valid", 32'(tx_valid), 32'd0);
        check("R1 rx_irq", 32'(rx_irq), 32'd0);
        check("R1 tx_irq", 32'(tx_irq), 32'd0);
        check("R1 op_mode", 32'(op_mode), 32'd0);
        bus_read(3'd0, rd);
        check("R1 data port before select", 32'(rd), 32'd0);
        read_status("R1 R9 status after reset", 16'h0000);

        // R8 modes
        bus_write(3'd4, 16'h0010, 2'b11);
        check("R8 standalone", 32'(op_mode), 32'd1);
        bus_write(3'd4, 16'h0080, 2'b11);
        check("R8 direction has no effect", 32'(op_mode), 32'd1);
        bus_read(3'd0, rd);
        check("R8 direction keeps read select", 32'(rd), 32'd0);
        bus_write(3'd4, 16'h0040, 2'b11);
        check("R8 mode 3", 32'(op_mode), 32'd3);
        bus_write(3'd4, 16'h0020, 2'b11);
        check("R8 mode 2", 32'(op_mode), 32'd2);
        bus_write(3'd4, 16'h1234, 2'b11);
        check("R8 unknown code", 32'(op_mode), 32'd2);

        // R11 other offsets
        bus_write(3'd6, 16'h0010, 2'b11);
        check("R11 write to offset 6", 32'(op_mode), 32'd2);
        bus_read(3'd2, rd);
        check("R11 read offset 2", 32'(rd), 32'd0);
        bus_read(3'd4, rd);
        check("R11 read command register", 32'(rd), 32'd0);
        bus_write(3'd4, 16'h0010, 2'b11);
        check("R8 standalone at init", 32'(op_mode), 32'd1);

        // receive vector table (R2 R3 R4 R9 R10)
        for (int v = 0; v < NV; v++) begin
            send_frame(int'(VECS[v].len), VECS[v].inner, VECS[v].ok);
            if (VECS[v].ok) check_held(int'(VECS[v].len), VECS[v].inner);
            else drops++;
            read_status("R4 R9 status drop count", {8'(drops), 8'h00});
        end

        // R5 frame arriving while one is held
        send_frame(6, 10'd6, 1'b1);
        send_frame(4, 10'd4, 1'b0);
        drops++;
        read_status("R5 R9 drop while held", {8'(drops), 8'h01});
        check_held(6, 10'd6);

        // transmit (R6 R7)
        tx_frame(5, 1'b1, 1'b1);
        tx_frame(8, 1'b0, 1'b0);
        tx_frame(1, 1'b1, 1'b0);

        // R7 empty end-of-frame
        bus_write(3'd4, 16'h0001, 2'b11);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R7 empty eof no valid", 32'(tx_valid), 32'd0);
            check("R7 empty eof no irq", 32'(tx_irq), 32'd0);
        end
        read_status("R9 idle status", {8'(drops), 8'h00});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule